// File: doc/BRIEF.md
# Log-Domain to Floating-Point Converter

This block turns a number held in logarithmic form into an ordinary floating-point word without denormals. The logarithmic input carries a two-bit class code, a sign bit, and a two's-complement fixed-point base-2 exponent. That exponent has `INT_W` integer bits and `FRAC_W` fraction bits. The output is a sign, an `EXP_W`-bit biased exponent and a `MANT_W`-bit fraction with a hidden leading one.

The integer part of the log exponent, once biased, becomes the float exponent. The fractional part `x` is turned into the mantissa `2^x`, which always lies in [1,2). The fraction is cut into `NUM_SLICES` equal slices, with the most significant slice first. Each slice addresses its own small table of partial powers. The partial powers are multiplied together one stage at a time, so only `NUM_SLICES-1` multiplications are needed and no single table of depth `2^FRAC_W` is built.

The block is fully pipelined: it accepts one operand per clock, and each result appears a fixed number of cycles later, qualified by a valid strobe.

Top module: `lns2fp_conv`

## Requirements
- R1: Class code 2'b00 (zero) yields exponent 0 and fraction 0.
- R2: Class code 2'b10 (infinity) yields an all-ones exponent and fraction 0.
- R3: Class code 2'b11 (not-a-number) yields an all-ones exponent and a fraction whose MSB is 1 and whose other bits are 0.
- R4: For class code 2'b01 (finite), the biased value is b = I + 2^(EXP_W-1) - 1, where I is the signed integer field `in_log[INT_W+FRAC_W-1:FRAC_W]`. When 1 <= b <= 2^EXP_W - 2, the output exponent is b.
- R5: A finite input with b <= 0 (this includes the most negative I) yields exponent 0 and fraction 0.
- R6: A finite input with b > 2^EXP_W - 2 yields infinity: an all-ones exponent and fraction 0.
- R7: For a normal result, the fraction is computed as follows.
  - The fraction field is split into `NUM_SLICES` slices of S = FRAC_W/NUM_SLICES bits, with slice 0 at the MSBs.
  - Slice j with value v gives the table entry T_j(v) = floor(2^(v / 2^(S(j+1))) * 2^P), where P = MANT_W+2.
  - The running product starts at T_0. Each later step is (acc * T_j) >> P.
  - The output fraction is bits [P-1:2] of the final product.
  - The exponent is never adjusted by the mantissa.
- R8: The output sign equals the input sign for every class.
- R9: Every input accepted with `in_valid` high produces exactly one output with `out_valid` high, exactly NUM_SLICES+1 clock cycles later, in order. Back-to-back inputs are accepted on every cycle.
- R10: While reset is asserted, and after it until the first valid input has had time to emerge, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_valid | input | 1 | Input operand is present |
| in_flags | input | 2 | Class code: 00 zero, 01 finite, 10 infinity, 11 not-a-number |
| in_sign | input | 1 | Sign of the value |
| in_log | input | INT_W+FRAC_W | Two's-complement log2 magnitude, integer bits above fraction bits |
| out_valid | output | 1 | Result is present |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Biased exponent |
| out_frac | output | MANT_W | Fraction without the hidden one |

## Verification
A wrong table entry or a broken product chain shows up as a wrong `out_frac` only for the fraction patterns that use the faulty slice value. It appears NUM_SLICES+1 cycles after that operand enters. For that reason, every fraction pattern is swept against every exponent and class. A misclassified exponent boundary shows at once as a zero or an infinity where a normal number was due, or the reverse. A dropped or duplicated valid bit in any stage shows as a result that arrives in the wrong cycle or that has no matching input.

// File: rtl/lns2fp_pkg.sv
package lns2fp_pkg;

  typedef enum logic [1:0] {
    KIND_ZERO = 2'b00,
    KIND_NORM = 2'b01,
    KIND_INF  = 2'b10,
    KIND_NAN  = 2'b11
  } kind_e;

  // Partial power for one slice, scaled by 2^frac_bits and truncated.
  // Evaluated only with constant arguments, at elaboration.
  function automatic int pow_entry(int slice_w, int slice_idx, int value, int frac_bits);
    real expo;
    real scaled;
    expo   = real'(value) / (2.0 ** (slice_w * (slice_idx + 1)));
    scaled = (2.0 ** expo) * (2.0 ** frac_bits);
    return $rtoi(scaled);
  endfunction

endpackage

// File: rtl/lns2fp_classify.sv
module lns2fp_classify
  import lns2fp_pkg::*;
#(
  parameter int INT_W = 5,
  parameter int EXP_W = 4
) (
  input  logic [1:0]       flags,
  input  logic [INT_W-1:0] ipart,
  output kind_e            kind,
  output logic [EXP_W-1:0] exp_biased
);
  localparam int XW = ((INT_W > EXP_W) ? INT_W : EXP_W) + 2;
  localparam logic signed [XW-1:0] BIAS_X = XW'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EXP_W) - 2);
  localparam logic [INT_W-1:0]     IMIN   = {1'b1, {(INT_W-1){1'b0}}};

  logic signed [XW-1:0] ext;
  logic signed [XW-1:0] biased;
  logic                 exp_under;
  logic                 exp_over;

  assign ext        = XW'(signed'(ipart));
  assign biased     = ext + BIAS_X;
  assign exp_under  = (ipart == IMIN) || (biased <= 0);
  assign exp_over   = biased > EMAX_X;
  assign exp_biased = biased[EXP_W-1:0];

  always_comb begin
    unique case (flags)
      2'b00:   kind = KIND_ZERO;
      2'b10:   kind = KIND_INF;
      2'b11:   kind = KIND_NAN;
      default: kind = exp_under ? KIND_ZERO : (exp_over ? KIND_INF : KIND_NORM);
    endcase
  end

  // Each R5 and R6 condition must land on exactly one class.
  always_comb begin
    assert_range_exclusive_R5: assert (!(exp_under && exp_over));
  end
endmodule

// File: rtl/lns2fp_pow_table.sv
module lns2fp_pow_table
  import lns2fp_pkg::*;
#(
  parameter int SLICE_W   = 3,
  parameter int SLICE_IDX = 0,
  parameter int FRAC_P    = 8
) (
  input  logic [SLICE_W-1:0] idx,
  output logic [FRAC_P:0]    val
);
  localparam int DEPTH = 1 << SLICE_W;

  logic [FRAC_P:0] rom [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_entry
    assign rom[j] = (FRAC_P + 1)'(pow_entry(SLICE_W, SLICE_IDX, j, FRAC_P));
  end

  assign val = rom[idx];

  // R7: every partial power lies in [1,2).
  always_comb begin
    assert_entry_unit_range_R7: assert (val[FRAC_P] == 1'b1);
  end
endmodule

// File: rtl/lns2fp_mul_stage.sv
module lns2fp_mul_stage #(
  parameter int VW     = 9,
  parameter int PASS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [VW-1:0]     acc_i,
  input  logic [VW-1:0]     fac_i,
  input  logic [PASS_W-1:0] pass_i,
  output logic              valid_o,
  output logic [VW-1:0]     acc_o,
  output logic [PASS_W-1:0] pass_o
);
  localparam int PW = 2 * VW;
  localparam int FP = VW - 1;

  logic [PW-1:0] prod;
  logic          prod_ge_two;
  logic          prod_lt_one;

  assign prod        = PW'(acc_i) * PW'(fac_i);
  assign prod_ge_two = prod[PW-1];
  assign prod_lt_one = !prod[PW-2];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_i;
    acc_o  <= prod[2*FP -: VW];
    pass_o <= pass_i;
  end

  // R7: the product of partial powers stays inside [1,2).
  assert_prod_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> (!prod_ge_two && !prod_lt_one));

  // R9: each stage delays valid by exactly one cycle.
  assert_stage_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid_o == $past(valid_i)));
endmodule

// File: rtl/lns2fp_conv.sv
module lns2fp_conv
  import lns2fp_pkg::*;
#(
  parameter int INT_W      = 5,
  parameter int FRAC_W     = 6,
  parameter int EXP_W      = 4,
  parameter int MANT_W     = 6,
  parameter int NUM_SLICES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_flags,
  input  logic                    in_sign,
  input  logic [INT_W+FRAC_W-1:0] in_log,
  output logic                    out_valid,
  output logic                    out_sign,
  output logic [EXP_W-1:0]        out_exp,
  output logic [MANT_W-1:0]       out_frac
);
  localparam int SLICE_W = FRAC_W / NUM_SLICES;
  localparam int FP      = MANT_W + 2;
  localparam int VW      = FP + 1;
  localparam int SIDE_W  = 1 + 2 + EXP_W;
  localparam int PARTS_W = NUM_SLICES * VW;
  localparam int PASS_W  = SIDE_W + PARTS_W;
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [MANT_W-1:0] NAN_FRAC = MANT_W'(1) << (MANT_W - 1);

  // Decode and table lookup
  kind_e            c_kind;
  logic [EXP_W-1:0] c_exp;
  logic [PARTS_W-1:0] c_parts;

  lns2fp_classify #(.INT_W(INT_W), .EXP_W(EXP_W)) u_classify (
    .flags      (in_flags),
    .ipart      (in_log[INT_W+FRAC_W-1:FRAC_W]),
    .kind       (c_kind),
    .exp_biased (c_exp)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    lns2fp_pow_table #(.SLICE_W(SLICE_W), .SLICE_IDX(s), .FRAC_P(FP)) u_tab (
      .idx (in_log[FRAC_W-1-s*SLICE_W -: SLICE_W]),
      .val (c_parts[s*VW +: VW])
    );
  end

  // Pipeline chain: index 0 is the lookup register
  logic              ch_valid [NUM_SLICES];
  logic [VW-1:0]     ch_acc   [NUM_SLICES];
  logic [PASS_W-1:0] ch_pass  [NUM_SLICES];

  always_ff @(posedge clk) begin
    if (!rst_n) ch_valid[0] <= 1'b0;
    else        ch_valid[0] <= in_valid;
    ch_acc[0]  <= c_parts[0 +: VW];
    ch_pass[0] <= {in_sign, c_kind, c_exp, c_parts};
  end

  for (genvar i = 1; i < NUM_SLICES; i++) begin : g_mul
    lns2fp_mul_stage #(.VW(VW), .PASS_W(PASS_W)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (ch_valid[i-1]),
      .acc_i   (ch_acc[i-1]),
      .fac_i   (ch_pass[i-1][i*VW +: VW]),
      .pass_i  (ch_pass[i-1]),
      .valid_o (ch_valid[i]),
      .acc_o   (ch_acc[i]),
      .pass_o  (ch_pass[i])
    );
  end

  // Output packing
  logic              f_valid;
  logic [VW-1:0]     f_acc;
  logic              f_sign;
  kind_e             f_kind;
  logic [EXP_W-1:0]  f_exp;
  logic [EXP_W-1:0]  n_exp;
  logic [MANT_W-1:0] n_frac;

  assign f_valid = ch_valid[NUM_SLICES-1];
  assign f_acc   = ch_acc[NUM_SLICES-1];
  assign f_sign  = ch_pass[NUM_SLICES-1][PASS_W-1];
  assign f_kind  = kind_e'(ch_pass[NUM_SLICES-1][PASS_W-2 -: 2]);
  assign f_exp   = ch_pass[NUM_SLICES-1][PARTS_W +: EXP_W];

  always_comb begin
    unique case (f_kind)
      KIND_ZERO: begin n_exp = '0;       n_frac = '0;       end
      KIND_INF:  begin n_exp = EXP_ONES; n_frac = '0;       end
      KIND_NAN:  begin n_exp = EXP_ONES; n_frac = NAN_FRAC; end
      default:   begin n_exp = f_exp;    n_frac = f_acc[FP-1 -: MANT_W]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= f_valid;
    out_sign <= f_sign;
    out_exp  <= n_exp;
    out_frac <= n_frac;
  end

  // R5: no denormals, so a zero exponent always carries a zero fraction.
  assert_zero_exp_clears_frac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exp == '0) |-> (out_frac == '0));

  // R3: an all-ones exponent carries either the infinity or the NaN fraction.
  assert_special_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exp == EXP_ONES) |-> (out_frac == '0 || out_frac == NAN_FRAC));

  // R4: a normal result never reaches the reserved exponent values.
  assert_norm_exp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_kind == KIND_NORM) |-> (f_exp != '0 && f_exp != EXP_ONES));

  // R7: the final product has its hidden one in place.
  assert_final_hidden_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid |-> f_acc[VW-1]);

  // R9: the output register delays valid by one cycle.
  assert_out_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(f_valid)));
endmodule

// File: tb/test_lns2fp_conv.sv
module test_lns2fp_conv;
  localparam int INT_W = 5, FRAC_W = 6, EXP_W = 4, MANT_W = 6, NUM_SLICES = 2;
  localparam int SW = FRAC_W / NUM_SLICES;
  localparam int P = MANT_W + 2;
  localparam int LAT = NUM_SLICES + 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 2;
  localparam int OW = 1 + EXP_W + MANT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_flags = '0;
  logic in_sign = 1'b0;
  logic [INT_W+FRAC_W-1:0] in_log = '0;
  logic out_valid;
  logic out_sign;
  logic [EXP_W-1:0] out_exp;
  logic [MANT_W-1:0] out_frac;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic done = 1'b0;

  logic [OW-1:0] exp_q [$];
  string tag_q [$];
  int cyc_q [$];

  always #4 clk = ~clk;

  lns2fp_conv #(.INT_W(INT_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MANT_W(MANT_W),
                .NUM_SLICES(NUM_SLICES)) i_lns2fp_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flags(in_flags),
    .in_sign(in_sign), .in_log(in_log), .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_frac(out_frac));

  always @(posedge clk) cyc <= cyc + 1;

  // Partial power for slice s, value v, per R7
  function automatic longint tab(int s, int v);
    real e;
    e = real'(v) / (2.0 ** (SW * (s + 1)));
    return longint'($rtoi((2.0 ** e) * (2.0 ** P)));
  endfunction

  function automatic void model(input int fl, input int sg, input int ip, input int fr,
                                output logic [OW-1:0] res, output string tag);
    int ival, b;
    longint acc;
    int e_out, f_out;
    ival = (ip >= (1 << (INT_W - 1))) ? ip - (1 << INT_W) : ip;
    b = ival + BIAS;
    e_out = 0; f_out = 0;
    if (fl == 0) begin tag = "R1 R8"; end
    else if (fl == 2) begin tag = "R2 R8"; e_out = (1 << EXP_W) - 1; end
    else if (fl == 3) begin tag = "R3 R8"; e_out = (1 << EXP_W) - 1; f_out = 1 << (MANT_W - 1); end
    else if (b <= 0) begin tag = "R5 R8"; end
    else if (b > EMAX) begin tag = "R6 R8"; e_out = (1 << EXP_W) - 1; end
    else begin
      tag = "R4 R7 R8";
      e_out = b;
      acc = tab(0, (fr >> (FRAC_W - SW)) & ((1 << SW) - 1));
      for (int s = 1; s < NUM_SLICES; s++)
        acc = (acc * tab(s, (fr >> (FRAC_W - SW * (s + 1))) & ((1 << SW) - 1))) >>> P;
      f_out = int'((acc >>> 2) & ((1 << MANT_W) - 1));
    end
    res = {sg[0], EXP_W'(e_out), MANT_W'(f_out)};
  endfunction

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9: output with no pending input, actual=%b expected=none",
                   {out_sign, out_exp, out_frac});
        end else begin
          logic [OW-1:0] e;
          string t;
          int c0;
          e = exp_q.pop_front(); t = tag_q.pop_front(); c0 = cyc_q.pop_front();
          if ({out_sign, out_exp, out_frac} !== e) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", t, {out_sign, out_exp, out_frac}, e);
          end
          checks++;
          if (cyc != c0 + LAT) begin
            fails++;
            $display("FAIL R9: latency actual=%0d expected=%0d", cyc - c0, LAT);
          end
        end
      end
    end
  end

  // Watchdog: a hung run counts as a failed check
  initial begin
    wait (cyc > 60000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R9: watchdog expired, actual=hung expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    n = 0;
    // R10: no valid output during reset
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R10: out_valid during reset actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R10: out_valid after reset actual=%b expected=0", out_valid);
    end
    // Exhaustive sweep, back-to-back with periodic idle gaps (R9)
    for (int fl = 0; fl < 4; fl++)
      for (int sg = 0; sg < 2; sg++)
        for (int ip = 0; ip < (1 << INT_W); ip++)
          for (int fr = 0; fr < (1 << FRAC_W); fr++) begin
            logic [OW-1:0] r;
            string t;
            if ((n % 97) == 96) begin
              in_valid = 1'b0;
              @(negedge clk);
            end
            model(fl, sg, ip, fr, r, t);
            in_valid = 1'b1;
            in_flags = 2'(fl);
            in_sign = sg[0];
            in_log = {INT_W'(ip), FRAC_W'(fr)};
            exp_q.push_back(r); tag_q.push_back(t); cyc_q.push_back(cyc);
            n++;
            @(negedge clk);
          end
    in_valid = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    // R9: every accepted input produced a result
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R9: missing outputs actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule